// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block holds the 32-bit control and status word that governs a SIMD floating-point execution unit. Software reads the word at any time and writes it through a single write port. A constant writable-bit mask is presented alongside, so software can learn which bits it may set. The arithmetic datapath reports exceptions as a six-bit class vector with a valid strobe. Each report sets sticky per-class flags, and it raises a one-cycle SIMD fault pulse when a reported class is unmasked.

A write that tries to set a bit outside the writable mask is refused. The word keeps its value, and a general-protection fault pulse is raised instead. The hardware reset loads 0x00001F80, which masks all six exception classes, clears every flag, selects round-to-nearest and disables both flush-to-zero and denormals-are-zero. The soft initialisation input leaves the word as it is. The parameter `DAZ_EN` selects whether the denormals-are-zero bit exists. Without it, bit 6 is reserved and reads as 0.

A small access state machine records what happened to the word on each clock edge. Its states are `ACC_IDLE` (no software access), `ACC_COMMIT` (a legal write was taken), `ACC_REJECT` (a write was refused) and `ACC_INIT` (soft init seen, word held). On every edge the next state is chosen from the inputs of that cycle, with this priority:
- A refused write leads to `ACC_REJECT`.
- Otherwise a legal write leads to `ACC_COMMIT`.
- Otherwise a soft init leads to `ACC_INIT`.
- Otherwise the machine goes to `ACC_IDLE`.

This choice is the same from every state. Reset enters `ACC_IDLE`. The protection fault output is high exactly while the machine is in `ACC_REJECT`.

Top module: `simd_fpcsr`

## Requirements
- R1: After hardware reset, `rd_data` reads 0x00001F80, and `gp_fault` and `simd_fault` are low.
- R2: Holding `soft_init` high, with no write and no report, leaves `rd_data` unchanged.
- R3: `wr_mask` reads 0x0000FFFF when `DAZ_EN`=1 and 0x0000FFBF when `DAZ_EN`=0. Bit 6 of the mask is the denormals-are-zero bit.
- R4: A write whose set bits all lie inside `wr_mask` appears on `rd_data` after the next rising edge, and no `gp_fault` is raised.
- R5: A write that sets any bit outside `wr_mask` leaves `rd_data` unchanged. `gp_fault` is high for exactly the one cycle after that edge. Bits outside the mask are bits 16–31, and bit 6 when `DAZ_EN`=0.
- R6: A report with `exc_valid` ORs `exc_bits[i]` into flag bit i (bits 0–5). Flags never clear except by a software write.
- R7: `simd_fault` is high for the one cycle after an edge at which `exc_valid` was high and some `exc_bits[i]` was 1 while mask bit 7+i of the held word was 0.
- R8: Clearing a mask bit whose flag is already set raises no `simd_fault`. Only a later unmasked report of that class does.
- R9: When a write and a report arrive in the same cycle, the write value (or the held value if the write is refused) is taken first and the reported flags are ORed on top.
- R10: Rounding control (bits 13–14) and flush-to-zero (bit 15) are written and read back as given, and bits 16–31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_init | input | 1 | Soft initialisation; leaves the word unchanged |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| exc_valid | input | 1 | Exception report strobe from the datapath |
| exc_bits | input | 6 | Reported exception classes, bit i = class i |
| rd_data | output | 32 | Current register word |
| wr_mask | output | 32 | Writable-bit mask |
| gp_fault | output | 1 | One-cycle pulse after a refused write |
| simd_fault | output | 1 | One-cycle pulse after an unmasked report |

## Verification
The bench builds two copies side by side, one with `DAZ_EN`=1 and one with `DAZ_EN`=0. The second copy makes bit 6 a reserved bit. This brings the refusal of a bit-6 write and the 0x0000FFBF mask within reach, next to the accepted denormals-are-zero write on the first copy. The supported copy covers the remaining behaviour: sticky flags, unmask-without-fault, and a report landing in the same cycle as a write.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int CSR_W     = 32;
    localparam int NUM_EXC   = 6;
    localparam int FLAG_LSB  = 0;
    localparam int DAZ_BIT   = 6;
    localparam int MASK_LSB  = 7;
    localparam int RC_LSB    = 13;
    localparam int FTZ_BIT   = 15;
    localparam int LIVE_W    = 16;
    localparam logic [CSR_W-1:0] RESET_VAL = 32'h0000_1F80;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_COMMIT = 2'd1,
        ACC_REJECT = 2'd2,
        ACC_INIT   = 2'd3
    } acc_state_t;

    function automatic logic [CSR_W-1:0] writable_mask(input bit daz_en);
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < LIVE_W; i++) m[i] = 1'b1;
        if (!daz_en) m[DAZ_BIT] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/fpcsr_wr_check.sv
module fpcsr_wr_check
    import fpcsr_pkg::*;
#(
    parameter bit DAZ_EN = 1'b1
) (
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] mask,
    output logic             wr_legal,
    output logic             wr_bad
);
    localparam logic [CSR_W-1:0] WMASK = writable_mask(DAZ_EN);

    logic reserved_hit;

    always_comb begin
        mask         = WMASK;
        reserved_hit = |(wr_data & ~WMASK);
        wr_legal     = wr_en && !reserved_hit;
        wr_bad       = wr_en && reserved_hit;
    end
endmodule

// File: rtl/fpcsr_exc_unit.sv
module fpcsr_exc_unit
    import fpcsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] exc_bits,
    input  logic [NUM_EXC-1:0] mask_cur,
    output logic [NUM_EXC-1:0] set_bits,
    output logic               simd_fault
);
    logic fault_d;

    always_comb begin
        set_bits = exc_valid ? exc_bits : '0;
        fault_d  = |(set_bits & ~mask_cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) simd_fault <= 1'b0;
        else        simd_fault <= fault_d;
    end
endmodule

// File: rtl/simd_fpcsr.sv
module simd_fpcsr
    import fpcsr_pkg::*;
#(
    parameter bit DAZ_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_init,
    input  logic               wr_en,
    input  logic [CSR_W-1:0]   wr_data,
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] exc_bits,
    output logic [CSR_W-1:0]   rd_data,
    output logic [CSR_W-1:0]   wr_mask,
    output logic               gp_fault,
    output logic               simd_fault
);
    logic [CSR_W-1:0]   csr_q, csr_d, base;
    logic [NUM_EXC-1:0] set_bits;
    logic               wr_legal, wr_bad;
    acc_state_t         acc_q, acc_d;

    fpcsr_wr_check #(.DAZ_EN(DAZ_EN)) u_wr_check (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mask     (wr_mask),
        .wr_legal (wr_legal),
        .wr_bad   (wr_bad)
    );

    fpcsr_exc_unit u_exc_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_valid  (exc_valid),
        .exc_bits   (exc_bits),
        .mask_cur   (csr_q[MASK_LSB +: NUM_EXC]),
        .set_bits   (set_bits),
        .simd_fault (simd_fault)
    );

    // Next access state: same choice from every state, refusal first.
    always_comb begin
        acc_d = ACC_IDLE;
        unique case (acc_q)
            ACC_IDLE, ACC_COMMIT, ACC_REJECT, ACC_INIT: begin
                if (wr_bad)         acc_d = ACC_REJECT;
                else if (wr_legal)  acc_d = ACC_COMMIT;
                else if (soft_init) acc_d = ACC_INIT;
                else                acc_d = ACC_IDLE;
            end
            default: acc_d = ACC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ACC_IDLE;
        else        acc_q <= acc_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        gp_fault = 1'b0;
        unique case (acc_q)
            ACC_REJECT: gp_fault = 1'b1;
            ACC_IDLE, ACC_COMMIT, ACC_INIT: gp_fault = 1'b0;
            default: gp_fault = 1'b0;
        endcase
    end

    // Word update: write value first, reported flags ORed on top.
    always_comb begin
        base  = wr_legal ? (wr_data & wr_mask) : csr_q;
        csr_d = base;
        csr_d[FLAG_LSB +: NUM_EXC] = base[FLAG_LSB +: NUM_EXC] | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= RESET_VAL;
        else        csr_q <= csr_d;
    end

    assign rd_data = csr_q;
endmodule

// File: rtl/simd_fpcsr_checker.sv
module simd_fpcsr_checker
    import fpcsr_pkg::*;
#(
    parameter bit DAZ_EN = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_init,
    input logic               wr_en,
    input logic [CSR_W-1:0]   wr_data,
    input logic               exc_valid,
    input logic [NUM_EXC-1:0] exc_bits,
    input logic [CSR_W-1:0]   rd_data,
    input logic [CSR_W-1:0]   wr_mask,
    input logic               gp_fault,
    input logic               simd_fault
);
    localparam logic [CSR_W-1:0] EXP_MASK = DAZ_EN ? 32'h0000_FFFF : 32'h0000_FFBF;

    logic bad_wr;
    assign bad_wr = wr_en && |(wr_data & ~EXP_MASK);

    p_mask_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask == EXP_MASK);

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0);

    p_init_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_init && !wr_en && !exc_valid |=> $stable(rd_data));

    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !bad_wr && !exc_valid |=> (rd_data == $past(wr_data)) && !gp_fault);

    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr && !exc_valid |=> $stable(rd_data) && gp_fault);

    p_gp_only_after_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !gp_fault);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[5:0] & $past(rd_data[5:0])) == $past(rd_data[5:0])));

    p_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && |(exc_bits & ~rd_data[12:7]) |=> simd_fault);

    p_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> !simd_fault);

    p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !bad_wr && exc_valid |=>
            rd_data == ($past(wr_data) | {26'h0, $past(exc_bits)}));

    logic unused_ok;
    assign unused_ok = ^{wr_data[5:0]};
endmodule

bind simd_fpcsr simd_fpcsr_checker #(.DAZ_EN(DAZ_EN)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_init  (soft_init),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .exc_valid  (exc_valid),
    .exc_bits   (exc_bits),
    .rd_data    (rd_data),
    .wr_mask    (wr_mask),
    .gp_fault   (gp_fault),
    .simd_fault (simd_fault)
);

// File: tb/simd_fpcsr_bench.sv
`timescale 1ns/1ps
module simd_fpcsr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_init = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_bits = '0;
    logic        wr_en_n = 1'b0;
    logic [31:0] wr_data_n = '0;

    logic [31:0] rd_data, wr_mask, rd_data_n, wr_mask_n;
    logic        gp_fault, simd_fault, gp_fault_n, simd_fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    simd_fpcsr #(.DAZ_EN(1'b1)) u_simd_fpcsr (
        .clk(clk), .rst_n(rst_n), .soft_init(soft_init),
        .wr_en(wr_en), .wr_data(wr_data),
        .exc_valid(exc_valid), .exc_bits(exc_bits),
        .rd_data(rd_data), .wr_mask(wr_mask),
        .gp_fault(gp_fault), .simd_fault(simd_fault)
    );

    simd_fpcsr #(.DAZ_EN(1'b0)) u_simd_fpcsr_nodaz (
        .clk(clk), .rst_n(rst_n), .soft_init(1'b0),
        .wr_en(wr_en_n), .wr_data(wr_data_n),
        .exc_valid(1'b0), .exc_bits(6'h0),
        .rd_data(rd_data_n), .wr_mask(wr_mask_n),
        .gp_fault(gp_fault_n), .simd_fault(simd_fault_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        soft_init = 1'b0; wr_en = 1'b0; exc_valid = 1'b0; exc_bits = '0;
        wr_en_n = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        idle_inputs();
    endtask

    task automatic do_report(input logic [5:0] b);
        exc_valid = 1'b1; exc_bits = b;
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R1 reset value", rd_data, 32'h1F80);
        check("R1 reset value nodaz", rd_data_n, 32'h1F80);
        check("R1 gp_fault low", {31'h0, gp_fault}, 32'h0);
        check("R1 simd_fault low", {31'h0, simd_fault}, 32'h0);
    endtask

    task automatic t_mask();
        check("R3 mask with daz", wr_mask, 32'h0000_FFFF);
        check("R3 mask without daz", wr_mask_n, 32'h0000_FFBF);
    endtask

    task automatic t_write_and_init();
        do_write(32'h0000_E0C5);
        check("R4 legal write", rd_data, 32'h0000_E0C5);
        check("R4 no gp_fault", {31'h0, gp_fault}, 32'h0);
        check("R10 rounding and ftz bits", {16'h0, rd_data[15:13], 13'h0}, 32'h0000_E000);
        soft_init = 1'b1;
        tick(); tick(); tick();
        idle_inputs();
        check("R2 init keeps word", rd_data, 32'h0000_E0C5);
    endtask

    task automatic t_reserved();
        do_write(32'h0001_0000);
        check("R5 reserved write refused", rd_data, 32'h0000_E0C5);
        check("R5 gp_fault raised", {31'h0, gp_fault}, 32'h1);
        tick();
        check("R5 gp_fault one cycle", {31'h0, gp_fault}, 32'h0);
        check("R10 upper bits zero", {16'h0, rd_data[31:16]}, 32'h0);
        wr_en_n = 1'b1; wr_data_n = 32'h0000_0040;
        tick();
        idle_inputs();
        check("R5 daz bit refused without daz", rd_data_n, 32'h1F80);
        check("R5 gp_fault without daz", {31'h0, gp_fault_n}, 32'h1);
        wr_en_n = 1'b1; wr_data_n = 32'h0000_6000;
        tick();
        idle_inputs();
        check("R4 legal write without daz", rd_data_n, 32'h6000);
        check("R4 no gp_fault without daz", {31'h0, gp_fault_n}, 32'h0);
    endtask

    task automatic t_flags();
        do_write(32'h1F80);
        do_report(6'b000101);
        check("R6 flags set", rd_data, 32'h1F85);
        check("R7 masked report no fault", {31'h0, simd_fault}, 32'h0);
        do_report(6'b010000);
        check("R6 flags accumulate", rd_data, 32'h1F95);
        tick(); tick();
        check("R6 flags sticky", rd_data, 32'h1F95);
    endtask

    task automatic t_fault();
        do_write(32'h1E80);
        do_report(6'b000010);
        check("R7 unmasked report faults", {31'h0, simd_fault}, 32'h1);
        check("R6 flag for unmasked class", rd_data, 32'h1E82);
        tick();
        check("R7 fault one cycle", {31'h0, simd_fault}, 32'h0);
        do_report(6'b000001);
        check("R7 masked class no fault", {31'h0, simd_fault}, 32'h0);
        check("R6 masked class flag", rd_data, 32'h1E83);
    endtask

    task automatic t_unmask();
        do_write(32'h1F81);
        do_write(32'h1F01);
        check("R8 unmask with flag set no fault", {31'h0, simd_fault}, 32'h0);
        tick();
        check("R8 still no fault", {31'h0, simd_fault}, 32'h0);
        check("R8 word after unmask", rd_data, 32'h1F01);
        do_report(6'b000001);
        check("R8 later occurrence faults", {31'h0, simd_fault}, 32'h1);
    endtask

    task automatic t_merge();
        wr_en = 1'b1; wr_data = 32'h1F80; exc_valid = 1'b1; exc_bits = 6'b100000;
        tick();
        idle_inputs();
        check("R9 write then flags", rd_data, 32'h1FA0);
        check("R9 masked class no fault", {31'h0, simd_fault}, 32'h0);
        wr_en = 1'b1; wr_data = 32'h8000_0000; exc_valid = 1'b1; exc_bits = 6'b000010;
        tick();
        idle_inputs();
        check("R9 refused write keeps word plus flags", rd_data, 32'h1FA2);
        check("R9 refused write gp_fault", {31'h0, gp_fault}, 32'h1);
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1'b1;
                tick();
                t_reset();
                t_mask();
                t_write_and_init();
                t_reserved();
                t_flags();
                t_fault();
                t_unmask();
                t_merge();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    fails++;
                    $display("FAIL watchdog: actual hung expected finished");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule